// File: doc/BRIEF.md
# NAND Controller Interrupt Aggregator

This block collects the interrupt causes of a NAND flash controller and folds them into a single interrupt line. Five event pulses arrive from the command sequencer, the ECC checker and the DMA engine: transfer done, uncorrectable ECC error, corrected ECC error, DMA boundary reached and bus error. Each pulse is latched into a sticky status register, but only when software has enabled that cause in a status-enable mask. A second mask, the signal-enable mask, selects which latched causes drive the interrupt output. Software clears latched causes by writing ones to the status register.

Two further status bits are not events but levels. They are recomputed on every clock from the fill level of the controller's data buffer, its capacity and the packet size of the command in flight. Write-ready means one more packet fits. Read-ready means one full packet is waiting. Status, ID and feature commands move half as many bytes per packet when the data interface runs in a double-data-rate mode, so the packet size is halved for them in that case.

Software reaches the three registers through a simple single-cycle access port. Register select 0 is the status-enable mask, 1 is the signal-enable mask, 2 is the status register, and 3 is an empty slot.

Top module: `irq_agg`

## Requirements
- R1: After reset, all three registers read 0 and `irq_o` is low.
- R2: Status bit positions are 0 write-ready, 1 read-ready, 2 transfer done, 3 uncorrectable ECC, 4 corrected ECC, 6 DMA boundary and 7 bus error. Register select 0 is status-enable, 1 is signal-enable, 2 is status and 3 reads 0. `acc_rdata` shows the selected register combinationally.
- R3: At a clock edge, an event pulse sets its status bit only if the status-enable bit held before that edge is 1. A set bit stays set until it is cleared.
- R4: A write to the status register clears each event bit (2, 3, 4, 6, 7) whose write-data bit is 1. Bits written with 0 are unchanged. An event arriving in the same cycle as a clear of its bit leaves the bit set.
- R5: `irq_o` is high exactly when some bit is 1 in both the signal-enable and the status registers. It follows register changes with no extra delay.
- R6: At every edge, status bit 0 becomes (status-enable bit 0) AND (free space >= effective packet size). Free space is capacity minus fill level, or 0 when the fill level exceeds the capacity.
- R7: At every edge, status bit 1 becomes (status-enable bit 1) AND (fill level >= effective packet size) AND (effective packet size != 0).
- R8: The effective packet size is `pkt_bytes` divided by two (rounded down) when `narrow_cmd` is 1 and `ddr_sel` is nonzero. Otherwise it is `pkt_bytes`.
- R9: Writes to bit 5 and bits 31:8 of any register are ignored, and those bits always read 0.
- R10: Writing 1 to status bits 0 or 1 has no lasting effect; those bits keep following R6 and R7.
- R11: Clearing a status-enable bit does not clear an already latched event bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| acc_en | input | 1 | Register access strobe |
| acc_we | input | 1 | Access is a write when 1 |
| acc_sel | input | 2 | Register select |
| acc_wdata | input | 32 | Write data |
| acc_rdata | output | 32 | Selected register contents |
| ev_xfer_done | input | 1 | Transfer-complete pulse |
| ev_ecc_uncorr | input | 1 | Uncorrectable ECC error pulse |
| ev_ecc_fixed | input | 1 | Corrected ECC error pulse |
| ev_dma_bound | input | 1 | DMA boundary pulse |
| ev_bus_err | input | 1 | Bus error pulse |
| fill_level | input | LVL_W | Bytes held in the data buffer |
| buf_cap | input | LVL_W | Capacity of the data buffer in bytes |
| pkt_bytes | input | PKT_W | Packet size of the active command |
| narrow_cmd | input | 1 | Active command is status, ID or feature access |
| ddr_sel | input | 2 | Data-interface mode, nonzero for DDR |
| irq_o | output | 1 | Interrupt request |

## Verification
The bench goes after four corner cases:
- A clear and an event hitting the same bit in one cycle. A design that gave priority to the clear would lose the event.
- Events that arrive while their enable is off, or in the same cycle the enable is written. A design that latched them, or that used the new enable value, would report causes software never asked for.
- The ready flags at exact boundaries: free space equal to the packet size, a fill level above the capacity, a zero packet size, and odd sizes halved in DDR mode. An off-by-one compare, an unsigned wrap in the free-space subtraction, or halving for the wrong commands shows up as a flag one cycle in the wrong state.
- Writes of all ones, which catch reserved bits that stick, and ready bits that latch a software write.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;

    localparam int unsigned REG_W = 32;

    // status bit positions
    localparam int unsigned B_WRRDY = 0;
    localparam int unsigned B_RDRDY = 1;
    localparam int unsigned B_DONE  = 2;
    localparam int unsigned B_ECCU  = 3;
    localparam int unsigned B_ECCC  = 4;
    localparam int unsigned B_DMAB  = 6;
    localparam int unsigned B_BUSE  = 7;

    // bits that exist in every register
    localparam logic [REG_W-1:0] LIVE_MASK  = 32'h0000_00DF;
    // bits of the status register recomputed from buffer level each cycle
    localparam logic [REG_W-1:0] LEVEL_MASK = 32'h0000_0003;
    // bits of the status register that latch event pulses
    localparam logic [REG_W-1:0] EVENT_MASK = LIVE_MASK & ~LEVEL_MASK;

    typedef enum logic [1:0] {
        SEL_STEN = 2'd0,
        SEL_SGEN = 2'd1,
        SEL_STAT = 2'd2,
        SEL_VOID = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic [REG_W-1:0] sten;
        logic [REG_W-1:0] sgen;
        logic [REG_W-1:0] stat;
    } irq_regs_t;

endpackage

// File: rtl/irq_agg_ready.sv
module irq_agg_ready #(
    parameter int unsigned LVL_W = 16,
    parameter int unsigned PKT_W = 11
) (
    input  logic [LVL_W-1:0] fill_level,
    input  logic [LVL_W-1:0] buf_cap,
    input  logic [PKT_W-1:0] pkt_bytes,
    input  logic             narrow_cmd,
    input  logic [1:0]       ddr_sel,
    output logic             wr_rdy,
    output logic             rd_rdy
);

    localparam int unsigned CMP_W = ((LVL_W > PKT_W) ? LVL_W : PKT_W) + 1;

    logic [CMP_W-1:0] lvl_x;
    logic [CMP_W-1:0] cap_x;
    logic [CMP_W-1:0] pkt_x;
    logic [CMP_W-1:0] eff_x;
    logic [CMP_W-1:0] room_x;
    logic             halve;

    always_comb begin
        lvl_x  = CMP_W'(fill_level);
        cap_x  = CMP_W'(buf_cap);
        pkt_x  = CMP_W'(pkt_bytes);
        // R8: DDR status/ID/feature transfers carry half the bytes per packet
        halve  = narrow_cmd && (ddr_sel != 2'b00);
        eff_x  = halve ? (pkt_x >> 1) : pkt_x;
        // R6: an overfilled buffer has no room, never a wrapped difference
        room_x = (lvl_x > cap_x) ? '0 : (cap_x - lvl_x);
        wr_rdy = (room_x >= eff_x);
        rd_rdy = (eff_x != '0) && (lvl_x >= eff_x);
    end

endmodule

// File: rtl/irq_agg_stat.sv
module irq_agg_stat
    import irq_agg_pkg::*;
(
    input  logic [REG_W-1:0] stat_q,
    input  logic [REG_W-1:0] sten_q,
    input  logic [REG_W-1:0] evt_vec,
    input  logic [REG_W-1:0] clr_vec,
    input  logic [REG_W-1:0] lvl_vec,
    output logic [REG_W-1:0] stat_d
);

    // reserved and unselected slices are intentionally dropped
    logic unused_slices;
    assign unused_slices = ^{stat_q, sten_q, evt_vec, clr_vec, lvl_vec};

    for (genvar i = 0; i < REG_W; i++) begin : g_bit
        if (!LIVE_MASK[i]) begin : g_rsvd
            assign stat_d[i] = 1'b0;
        end else if (LEVEL_MASK[i]) begin : g_level
            // R6, R7, R10: recomputed each cycle, software writes do not stick
            assign stat_d[i] = sten_q[i] & lvl_vec[i];
        end else begin : g_event
            // R3, R4: sticky, set gated by enable, set beats clear
            assign stat_d[i] = (stat_q[i] & ~clr_vec[i]) | (evt_vec[i] & sten_q[i]);
        end
    end

endmodule

// File: rtl/irq_agg_port.sv
module irq_agg_port
    import irq_agg_pkg::*;
(
    input  logic             acc_en,
    input  logic             acc_we,
    input  logic [1:0]       acc_sel,
    input  logic [REG_W-1:0] acc_wdata,
    input  irq_regs_t        regs_q,
    output logic             sten_wr,
    output logic             sgen_wr,
    output logic [REG_W-1:0] wr_val,
    output logic [REG_W-1:0] clr_vec,
    output logic [REG_W-1:0] rdata
);

    reg_sel_e sel;
    logic     wr;

    always_comb begin
        sel     = reg_sel_e'(acc_sel);
        wr      = acc_en && acc_we;
        // R9: reserved bits never reach storage
        wr_val  = acc_wdata & LIVE_MASK;
        sten_wr = wr && (sel == SEL_STEN);
        sgen_wr = wr && (sel == SEL_SGEN);
        clr_vec = (wr && (sel == SEL_STAT)) ? (acc_wdata & EVENT_MASK) : '0;
        unique case (sel)
            SEL_STEN: rdata = regs_q.sten;
            SEL_SGEN: rdata = regs_q.sgen;
            SEL_STAT: rdata = regs_q.stat;
            default:  rdata = '0;
        endcase
    end

endmodule

// File: rtl/irq_agg.sv
module irq_agg
    import irq_agg_pkg::*;
#(
    parameter int unsigned LVL_W = 16,
    parameter int unsigned PKT_W = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             acc_en,
    input  logic             acc_we,
    input  logic [1:0]       acc_sel,
    input  logic [31:0]      acc_wdata,
    output logic [31:0]      acc_rdata,
    input  logic             ev_xfer_done,
    input  logic             ev_ecc_uncorr,
    input  logic             ev_ecc_fixed,
    input  logic             ev_dma_bound,
    input  logic             ev_bus_err,
    input  logic [LVL_W-1:0] fill_level,
    input  logic [LVL_W-1:0] buf_cap,
    input  logic [PKT_W-1:0] pkt_bytes,
    input  logic             narrow_cmd,
    input  logic [1:0]       ddr_sel,
    output logic             irq_o
);

    irq_regs_t        regs_q;
    irq_regs_t        regs_d;
    logic             sten_wr;
    logic             sgen_wr;
    logic [REG_W-1:0] wr_val;
    logic [REG_W-1:0] clr_vec;
    logic [REG_W-1:0] evt_vec;
    logic [REG_W-1:0] lvl_vec;
    logic [REG_W-1:0] stat_nx;
    logic             wr_rdy;
    logic             rd_rdy;

    irq_agg_port u_port (
        .acc_en    (acc_en),
        .acc_we    (acc_we),
        .acc_sel   (acc_sel),
        .acc_wdata (acc_wdata),
        .regs_q    (regs_q),
        .sten_wr   (sten_wr),
        .sgen_wr   (sgen_wr),
        .wr_val    (wr_val),
        .clr_vec   (clr_vec),
        .rdata     (acc_rdata)
    );

    irq_agg_ready #(
        .LVL_W (LVL_W),
        .PKT_W (PKT_W)
    ) u_ready (
        .fill_level (fill_level),
        .buf_cap    (buf_cap),
        .pkt_bytes  (pkt_bytes),
        .narrow_cmd (narrow_cmd),
        .ddr_sel    (ddr_sel),
        .wr_rdy     (wr_rdy),
        .rd_rdy     (rd_rdy)
    );

    always_comb begin
        evt_vec         = '0;
        evt_vec[B_DONE] = ev_xfer_done;
        evt_vec[B_ECCU] = ev_ecc_uncorr;
        evt_vec[B_ECCC] = ev_ecc_fixed;
        evt_vec[B_DMAB] = ev_dma_bound;
        evt_vec[B_BUSE] = ev_bus_err;
        lvl_vec          = '0;
        lvl_vec[B_WRRDY] = wr_rdy;
        lvl_vec[B_RDRDY] = rd_rdy;
    end

    irq_agg_stat u_stat (
        .stat_q  (regs_q.stat),
        .sten_q  (regs_q.sten),
        .evt_vec (evt_vec),
        .clr_vec (clr_vec),
        .lvl_vec (lvl_vec),
        .stat_d  (stat_nx)
    );

    always_comb begin
        regs_d = regs_q;
        if (sten_wr) begin
            regs_d.sten = wr_val;
        end
        if (sgen_wr) begin
            regs_d.sgen = wr_val;
        end
        regs_d.stat = stat_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            regs_q <= '0;
        end else begin
            regs_q <= regs_d;
        end
    end

    // R5: level output straight from the registers
    assign irq_o = |(regs_q.sgen & regs_q.stat);

endmodule

// File: rtl/irq_agg_chk.sv
module irq_agg_chk #(
    parameter int unsigned LVL_W = 16,
    parameter int unsigned PKT_W = 11
) (
    input logic             clk,
    input logic             rst_n,
    input logic             stat_wr,
    input logic             wd2,
    input logic             wd7,
    input logic             ev_bus_err,
    input logic [LVL_W-1:0] fill_level,
    input logic [LVL_W-1:0] buf_cap,
    input logic [PKT_W-1:0] pkt_bytes,
    input logic             irq_o,
    input logic             sten0,
    input logic             sten7,
    input logic [31:0]      sgen,
    input logic             st0,
    input logic             st1,
    input logic             st2,
    input logic             st7
);

    // R3: a latched transfer-done bit survives until written with 1
    a_r3_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (st2 && !(stat_wr && wd2)) |=> st2);

    // R3: with the enable off, a cleared bus-error bit stays clear
    a_r3_gated: assert property (@(posedge clk) disable iff (!rst_n)
        (!sten7 && !st7) |=> !st7);

    // R4: a clear with no competing event empties the bit
    a_r4_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_wr && wd7 && !ev_bus_err) |=> !st7);

    // R5: no signal enable, no interrupt
    a_r5_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (sgen == 32'd0) |-> !irq_o);

    // R5: an enabled, latched cause raises the line
    a_r5_follow: assert property (@(posedge clk) disable iff (!rst_n)
        (sgen[2] && st2) |-> irq_o);

    // R6: a full buffer with a packet of two or more bytes has no room
    a_r6_full: assert property (@(posedge clk) disable iff (!rst_n)
        ((pkt_bytes >= PKT_W'(2)) && (fill_level >= buf_cap)) |=> !st0);

    // R6: write-ready needs its enable at the previous edge
    a_r6_enable: assert property (@(posedge clk) disable iff (!rst_n)
        !sten0 |=> !st0);

    // R7: a zero packet size never reports read-ready
    a_r7_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (pkt_bytes == '0) |=> !st1);

endmodule

bind irq_agg irq_agg_chk #(
    .LVL_W (LVL_W),
    .PKT_W (PKT_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .stat_wr    (acc_en && acc_we && (acc_sel == 2'd2)),
    .wd2        (acc_wdata[2]),
    .wd7        (acc_wdata[7]),
    .ev_bus_err (ev_bus_err),
    .fill_level (fill_level),
    .buf_cap    (buf_cap),
    .pkt_bytes  (pkt_bytes),
    .irq_o      (irq_o),
    .sten0      (regs_q.sten[0]),
    .sten7      (regs_q.sten[7]),
    .sgen       (regs_q.sgen),
    .st0        (regs_q.stat[0]),
    .st1        (regs_q.stat[1]),
    .st2        (regs_q.stat[2]),
    .st7        (regs_q.stat[7])
);

// File: tb/irq_agg_bench.sv
`timescale 1ns/1ps
module irq_agg_bench;

    localparam int LVL_W = 16;
    localparam int PKT_W = 11;

    logic             clk = 1'b0;
    logic             rst_n;
    logic             acc_en, acc_we;
    logic [1:0]       acc_sel;
    logic [31:0]      acc_wdata;
    logic [31:0]      acc_rdata;
    logic [4:0]       evs;
    logic [LVL_W-1:0] fill_level, buf_cap;
    logic [PKT_W-1:0] pkt_bytes;
    logic             narrow_cmd;
    logic [1:0]       ddr_sel;
    logic             irq_o;

    always #2 clk = ~clk;

    irq_agg #(.LVL_W(LVL_W), .PKT_W(PKT_W)) u_irq_agg (
        .clk(clk), .rst_n(rst_n), .acc_en(acc_en), .acc_we(acc_we),
        .acc_sel(acc_sel), .acc_wdata(acc_wdata), .acc_rdata(acc_rdata),
        .ev_xfer_done(evs[0]), .ev_ecc_uncorr(evs[1]), .ev_ecc_fixed(evs[2]),
        .ev_dma_bound(evs[3]), .ev_bus_err(evs[4]),
        .fill_level(fill_level), .buf_cap(buf_cap), .pkt_bytes(pkt_bytes),
        .narrow_cmd(narrow_cmd), .ddr_sel(ddr_sel), .irq_o(irq_o)
    );

    int    n_vec = 0;
    int    n_bad = 0;
    bit    done  = 0;
    string tag   = "R1";
    logic [31:0] m_sten, m_sgen, m_stat;

    // behavioural reference, updated on every rising edge
    always @(posedge clk) begin
        if (!rst_n) begin
            m_sten = 0; m_sgen = 0; m_stat = 0;
        end else begin
            int eff, room, lvl, cap;
            logic [31:0] ev, clr, nstat;
            bit wr, rd;
            lvl  = int'(fill_level);
            cap  = int'(buf_cap);
            eff  = (narrow_cmd && ddr_sel != 0) ? int'(pkt_bytes) / 2 : int'(pkt_bytes);
            room = (lvl > cap) ? 0 : cap - lvl;
            wr   = room >= eff;
            rd   = (eff != 0) && (lvl >= eff);
            ev   = {24'd0, evs[4], evs[3], 1'b0, evs[2], evs[1], evs[0], 2'b00};
            clr  = (acc_en && acc_we && acc_sel == 2) ? (acc_wdata & 32'hDC) : 0;
            nstat = (((m_stat & ~clr) | (ev & m_sten)) & 32'hDC)
                  | (m_sten & {30'd0, rd, wr});
            if (acc_en && acc_we && acc_sel == 0) m_sten = acc_wdata & 32'hDF;
            if (acc_en && acc_we && acc_sel == 1) m_sgen = acc_wdata & 32'hDF;
            m_stat = nstat;
        end
    end

    task automatic check();
        logic [31:0] exp_rd;
        logic        exp_irq;
        case (acc_sel)
            2'd0:    exp_rd = m_sten;
            2'd1:    exp_rd = m_sgen;
            2'd2:    exp_rd = m_stat;
            default: exp_rd = 0;
        endcase
        exp_irq = (m_sgen & m_stat) != 0;
        n_vec++;
        if (acc_rdata !== exp_rd || irq_o !== exp_irq) begin
            n_bad++;
            $display("FAIL %s sel=%0d rdata got %h exp %h, irq got %b exp %b",
                     tag, acc_sel, acc_rdata, exp_rd, irq_o, exp_irq);
        end
    endtask

    // check the previous cycle's outcome, then return inputs to idle
    task automatic cyc();
        @(negedge clk);
        if (rst_n) check();
        acc_en = 0; acc_we = 0; acc_sel = 2'd2; acc_wdata = 0; evs = 0;
    endtask

    task automatic wreg(input logic [1:0] sel, input logic [31:0] val);
        cyc();
        acc_en = 1; acc_we = 1; acc_sel = sel; acc_wdata = val;
    endtask

    task automatic peek(input logic [1:0] sel);
        cyc();
        acc_sel = sel;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: run did not finish, got hang exp completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        rst_n = 0; acc_en = 0; acc_we = 0; acc_sel = 0; acc_wdata = 0; evs = 0;
        fill_level = 0; buf_cap = 16'd64; pkt_bytes = 11'd16; narrow_cmd = 0; ddr_sel = 0;
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1;

        // R1: reset contents of every register, irq low
        tag = "R1";
        for (int s = 0; s < 4; s++) peek(2'(s));
        cyc();

        // R3: events with enable off are dropped
        tag = "R3";
        cyc(); evs = 5'h1F;
        cyc(); evs = 5'h1F;
        peek(2); cyc();

        // R2: each cause lands on its own bit
        tag = "R2";
        wreg(0, 32'hFF);
        for (int b = 0; b < 5; b++) begin
            cyc(); evs = 5'(1 << b);
            peek(2);
        end
        peek(0); peek(3);

        // R4: write-one-to-clear, zeros ignored, event beats clear
        tag = "R4";
        wreg(2, 32'h04); peek(2);
        wreg(2, 32'h00); peek(2);
        wreg(2, 32'h80); evs = 5'h10; peek(2);
        wreg(2, 32'hFF); peek(2);

        // R11: disabling a cause keeps what is latched
        tag = "R11";
        cyc(); evs = 5'h09;
        wreg(0, 32'h00); evs = 5'h02;
        peek(2); peek(0);

        // R5: signal mask drives the line
        tag = "R5";
        wreg(1, 32'h04); peek(2);
        wreg(1, 32'h80); peek(2);
        wreg(1, 32'h01); peek(1);
        wreg(2, 32'hFF); peek(2);

        // R6 and R7: boundaries of the ready flags
        tag = "R6";
        wreg(0, 32'h03);
        buf_cap = 64; pkt_bytes = 16;
        fill_level = 48; peek(2); cyc();
        fill_level = 49; peek(2); cyc();
        fill_level = 70; peek(2); cyc();
        tag = "R7";
        fill_level = 15; peek(2); cyc();
        fill_level = 16; peek(2); cyc();
        pkt_bytes = 0; fill_level = 5; peek(2); cyc();
        pkt_bytes = 0; fill_level = 0; peek(2); cyc();

        // R8: halving only for narrow commands in DDR mode
        tag = "R8";
        pkt_bytes = 9; fill_level = 4; narrow_cmd = 1; ddr_sel = 2'd1; peek(2); cyc();
        ddr_sel = 2'd0; peek(2); cyc();
        narrow_cmd = 0; ddr_sel = 2'd2; peek(2); cyc();
        narrow_cmd = 1; ddr_sel = 2'd3; fill_level = 60; peek(2); cyc();
        pkt_bytes = 1; fill_level = 0; peek(2); cyc();
        narrow_cmd = 0; ddr_sel = 0;

        // R9: reserved bits ignored, read as zero
        tag = "R9";
        wreg(0, 32'hFFFF_FFFF); peek(0);
        wreg(1, 32'hFFFF_FF20); peek(1);
        wreg(2, 32'hFFFF_FF20); peek(2);
        wreg(1, 32'h0); wreg(0, 32'h0);

        // R10: software cannot park the ready bits
        tag = "R10";
        pkt_bytes = 16; fill_level = 0; buf_cap = 8;
        wreg(2, 32'h03); peek(2); cyc();
        wreg(0, 32'h01); wreg(2, 32'h03); peek(2); cyc();

        // mixed traffic against the reference
        tag = "R3 R4 R5 R6 R7 R8";
        for (int n = 0; n < 4000; n++) begin
            cyc();
            if (n % 40 == 0) begin
                buf_cap    = LVL_W'(8 + $urandom % 64);
                pkt_bytes  = PKT_W'($urandom % 20);
                narrow_cmd = 1'($urandom);
                ddr_sel    = 2'($urandom);
            end
            fill_level = LVL_W'($urandom % (int'(buf_cap) + 4));
            evs        = 5'($urandom & $urandom);
            acc_sel    = 2'($urandom);
            acc_wdata  = $urandom;
            acc_en     = ($urandom % 4) == 0;
            acc_we     = 1'($urandom);
        end
        cyc();

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule